// File: doc/BRIEF.md
# Oscillator Amplitude Compensation Timer

This block is a free-running timer clocked by the 32 kHz low-frequency clock. It periodically asks the oscillator control logic to re-run its amplitude compensation. The interval is set by a small floating-point code: a 5-bit mantissa and a 3-bit exponent. Together they give an interval of (mantissa*16+15)*2^exponent clock cycles. A code of all zeros switches the timer off.

In active mode an expiry produces a one-cycle request at once. While the chip is in powerdown an expiry is only remembered in a pending flag. The request is then released together with the next recharge strobe, or on the first active cycle if powerdown ends first. Several expiries that pile up while pending give a single request. Any change of the interval code restarts the count from the full new interval.

Top module: `osc_amp_timer`

## Requirements
- R1: In active mode with a non-zero code, consecutive requests are exactly P = (mantissa*16+15)*2^exponent cycles apart. The mantissa is the 5-bit input and the exponent is the 3-bit input.
- R2: With mantissa 0 and exponent 0 the timer is off. No request is produced while the code is zero, and any pending expiry is discarded.
- R3: A change of either period field restarts the count. The first request comes P+1 clock edges after the first edge that samples the new code, counting that edge as edge 1.
- R4: While powerdown is high and the recharge strobe is low, no request is issued in the following cycle.
- R5: If the pending flag is set, a recharge strobe seen at an edge during powerdown gives a request after that edge. A recharge strobe with nothing pending gives no request.
- R6: Any number of expiries during one powerdown interval yield one single deferred request, and the flag clears when that request is issued.
- R7: If powerdown ends while an expiry is pending, the request is issued at the first edge that samples powerdown low.
- R8: The request output is registered and high for one cycle per request. It is low from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz low-frequency clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| per_mant_i | input | 5 | Period mantissa |
| per_exp_i | input | 3 | Period exponent |
| pwrdn_i | input | 1 | High while the chip is in powerdown |
| recharge_i | input | 1 | One-cycle strobe at each recharge event |
| comp_req_o | output | 1 | One-cycle amplitude compensation request |

## Verification
The assertions assume that the period fields, the powerdown flag and the recharge strobe are all synchronous to the timer clock. They also assume the recharge strobe lasts one cycle per event. The bench meets this by changing every input only on the falling edge and raising the strobe for exactly one cycle. It does not move the period code while it measures an interval. It reads the request one time unit after each rising edge, so that the edge counts in R1 and R3 line up with the registered output.

// File: rtl/osc_amp_timer_pkg.sv
package osc_amp_timer_pkg;

  // Width of the counter needed for a given code shape.
  function automatic int unsigned cnt_width(input int unsigned mant_w,
                                            input int unsigned lsb_w,
                                            input int unsigned exp_w);
    return mant_w + lsb_w + (2 ** exp_w) - 1;
  endfunction

endpackage

// File: rtl/oat_period_dec.sv
module oat_period_dec #(
  parameter int unsigned MANT_W = 5,
  parameter int unsigned EXP_W  = 3,
  parameter int unsigned LSB_W  = 4,
  parameter int unsigned CNT_W  = 16
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic [EXP_W-1:0]  exp_i,
  output logic [CNT_W-1:0]  period_m1_o,
  output logic              enable_o
);

  localparam int unsigned BASE_W = MANT_W + LSB_W;

  logic [CNT_W-1:0] stage [EXP_W+1];

  assign stage[0] = CNT_W'({mant_i, {LSB_W{1'b1}}});

  // Barrel shifter, one stage per exponent bit.
  for (genvar i = 0; i < EXP_W; i++) begin : g_shift
    assign stage[i+1] = exp_i[i] ? (stage[i] << (2 ** i)) : stage[i];
  end

  assign period_m1_o = stage[EXP_W] - CNT_W'(1);
  assign enable_o    = (mant_i != '0) || (exp_i != '0);

endmodule

// File: rtl/oat_cfg_track.sv
module oat_cfg_track #(
  parameter int unsigned CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             chg_o
);

  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;
  logic             cfg_en;

  always_comb begin
    cfg_en = (cfg_i != cfg_q);
    cfg_d  = cfg_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign chg_o = cfg_en;

endmodule

// File: rtl/oat_down_cnt.sv
module oat_down_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] period_m1_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             expire;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (en_i) begin
      cnt_en = 1'b1;
      if (load_i) begin
        cnt_d = period_m1_i;
      end else if (cnt_q == '0) begin
        cnt_d  = period_m1_i;
        expire = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expire_o = expire;

endmodule

// File: rtl/oat_req_ctl.sv
module oat_req_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic expire_i,
  input  logic pwrdn_i,
  input  logic recharge_i,
  output logic pend_o,
  output logic req_o
);

  logic pend_q, pend_d;
  logic req_q, req_d;
  logic issue_pend;

  always_comb begin
    issue_pend = pend_q && (!pwrdn_i || recharge_i);
    req_d      = en_i && (issue_pend || (expire_i && !pwrdn_i));
    pend_d     = en_i && ((pend_q && !issue_pend) || (expire_i && pwrdn_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      req_q  <= req_d;
    end
  end

  assign pend_o = pend_q;
  assign req_o  = req_q;

endmodule

// File: rtl/osc_amp_timer.sv
module osc_amp_timer #(
  parameter int unsigned MANT_W = 5,
  parameter int unsigned EXP_W  = 3,
  parameter int unsigned LSB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MANT_W-1:0] per_mant_i,
  input  logic [EXP_W-1:0]  per_exp_i,
  input  logic              pwrdn_i,
  input  logic              recharge_i,
  output logic              comp_req_o
);

  localparam int unsigned CNT_W = osc_amp_timer_pkg::cnt_width(MANT_W, LSB_W, EXP_W);
  localparam int unsigned CFG_W = MANT_W + EXP_W;

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  logic [CNT_W-1:0] period_m1;
  logic             tmr_en;
  logic             cfg_chg;
  logic             expire;
  logic             pend;

  oat_period_dec #(
    .MANT_W(MANT_W), .EXP_W(EXP_W), .LSB_W(LSB_W), .CNT_W(CNT_W)
  ) u_dec (
    .mant_i      (per_mant_i),
    .exp_i       (per_exp_i),
    .period_m1_o (period_m1),
    .enable_o    (tmr_en)
  );

  oat_cfg_track #(.CFG_W(CFG_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .cfg_i ({per_mant_i, per_exp_i}),
    .chg_o (cfg_chg)
  );

  oat_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .en_i        (tmr_en),
    .load_i      (cfg_chg),
    .period_m1_i (period_m1),
    .expire_o    (expire)
  );

  oat_req_ctl u_req (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .en_i       (tmr_en),
    .expire_i   (expire),
    .pwrdn_i    (pwrdn_i),
    .recharge_i (recharge_i),
    .pend_o     (pend),
    .req_o      (comp_req_o)
  );

endmodule

// File: rtl/osc_amp_timer_chk.sv
module osc_amp_timer_chk #(
  parameter int unsigned MANT_W = 5,
  parameter int unsigned EXP_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MANT_W-1:0] per_mant_i,
  input logic [EXP_W-1:0]  per_exp_i,
  input logic              pwrdn_i,
  input logic              recharge_i,
  input logic              pend,
  input logic              comp_req_o
);

  logic code_on;
  assign code_on = (per_mant_i != '0) || (per_exp_i != '0);

  // R2
  off_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !code_on |=> !comp_req_o);

  // R4
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrdn_i && !recharge_i) |=> !comp_req_o);

  // R5
  recharge_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrdn_i && recharge_i && pend && code_on) |=> comp_req_o);

  // R7
  wake_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwrdn_i && pend && code_on) |=> comp_req_o);

  // R6
  pend_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_i |=> !pend);

endmodule

bind osc_amp_timer osc_amp_timer_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .per_mant_i (per_mant_i),
  .per_exp_i  (per_exp_i),
  .pwrdn_i    (pwrdn_i),
  .recharge_i (recharge_i),
  .pend       (pend),
  .comp_req_o (comp_req_o)
);

// File: tb/osc_amp_timer_tb.sv
`timescale 1ns/1ps
module osc_amp_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] mant = '0;
  logic [2:0] expo = '0;
  logic       pwrdn = 1'b0;
  logic       rchg = 1'b0;
  logic       req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  osc_amp_timer u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .per_mant_i (mant),
    .per_exp_i  (expo),
    .pwrdn_i    (pwrdn),
    .recharge_i (rchg),
    .comp_req_o (req)
  );

  task automatic chk(input string tag, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic step(output logic r);
    @(posedge clk);
    #1;
    r = req;
  endtask

  task automatic set_cfg(input int m, input int e);
    @(negedge clk);
    mant = 5'(m);
    expo = 3'(e);
  endtask

  // Counts request pulses over n edges.
  task automatic count_pulses(input int n, output int cnt);
    logic r;
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      step(r);
      if (r) cnt++;
    end
  endtask

  // R1 R3: new code, first pulse at edge P+1, next at 2P+1, none else.
  task automatic measure(input int m, input int e);
    int p, first, second, cnt;
    logic r;
    p = (m * 16 + 15) << e;
    first = -1; second = -1; cnt = 0;
    set_cfg(m, e);
    for (int n = 1; n <= 2 * p + 2; n++) begin
      step(r);
      if (r) begin
        cnt++;
        if (first < 0) first = n;
        else if (second < 0) second = n;
      end
    end
    chk($sformatf("R3 first request m=%0d e=%0d", m, e), first, p + 1);
    chk($sformatf("R1 spacing m=%0d e=%0d", m, e), second - first, p);
    chk($sformatf("R8 pulses in window m=%0d e=%0d", m, e), cnt, 2);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    logic r;
    // R8 reset state
    #1;
    chk("R8 output during reset", int'(req), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 output after reset", int'(req), 0);

    // R2 zero code stays silent
    count_pulses(300, cnt);
    chk("R2 no request with zero code", cnt, 0);

    // R1 R3 sweeps
    for (int m = 1; m < 32; m++) measure(m, 0);
    for (int e = 1; e < 8; e++) measure(0, e);
    for (int e = 1; e < 4; e++) measure(31, e);
    measure(2, 7);

    // R4 R5 R6: powerdown with P=31
    @(negedge clk);
    pwrdn = 1'b1;
    set_cfg(1, 0);
    count_pulses(100, cnt);
    chk("R4 no request in powerdown", cnt, 0);
    @(negedge clk); rchg = 1'b1;
    step(r);
    chk("R5 request on recharge with pending", int'(r), 1);
    @(negedge clk); rchg = 1'b0;
    step(r);
    chk("R6 single request for several expiries", int'(r), 0);
    @(negedge clk); rchg = 1'b1;
    step(r);
    chk("R5 no request on recharge without pending", int'(r), 0);
    @(negedge clk); rchg = 1'b0;
    count_pulses(40, cnt);
    chk("R4 expiry in powerdown deferred", cnt, 0);

    // R7 leaving powerdown with pending
    @(negedge clk); pwrdn = 1'b0;
    step(r);
    chk("R7 request on first active cycle", int'(r), 1);
    step(r);
    chk("R8 request lasts one cycle", int'(r), 0);

    // R2 zero code discards pending
    @(negedge clk); pwrdn = 1'b1;
    count_pulses(40, cnt);
    set_cfg(0, 0);
    count_pulses(3, cnt);
    @(negedge clk); rchg = 1'b1;
    step(r);
    chk("R2 recharge with zero code", int'(r), 0);
    @(negedge clk); rchg = 1'b0;
    set_cfg(1, 0);
    @(negedge clk); rchg = 1'b1;
    step(r);
    chk("R2 pending dropped by zero code", int'(r), 0);
    @(negedge clk); rchg = 1'b0; pwrdn = 1'b0;
    count_pulses(5, cnt);
    chk("R2 nothing pending on wake", cnt, 0);
    set_cfg(0, 0);
    count_pulses(200, cnt);
    chk("R2 active with zero code", cnt, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule